// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block watches for a stalled program. A counter advances on a slow tick input and is cleared by a restart strobe. If software does not restart it before the selected timeout, the block raises an interrupt, drives a system-reset output, or raises an interrupt first and then resets on the next timeout. The two enable bits in the control register select the mode.

Software reaches the block through a simple byte-wide register port. There is a control register, a reset-flag register and a key register. The control register guards itself: a write to it lands only if the key byte was written a few cycles earlier. This makes a runaway program unlikely to switch the watchdog off. Acknowledging the interrupt in the combined mode disarms the interrupt enable. The next timeout then resets the system unless software re-arms the interrupt.

Top module: `wdog_irq_rst`

## Requirements
- R1: After reset the control register reads 0x00, the reset-flag register reads 0x00, and `irq` and `sys_rst_out` are low.
- R2: The control register at address 0x31 reads as: bit 7 timeout flag, bit 6 interrupt enable, bit 5 prescale bit 3, bit 4 always 0, bit 3 reset enable, bits 2..0 prescale bits 2..0.
- R3: A timeout occurs on the 2^(BASE_SHIFT+P)-th tick after a restart, where P is the 4-bit prescale code for codes 0 to 9. Codes 10 to 15 act as code 0. Only cycles with `tick` high advance the counter, and `wd_restart` clears it.
- R4: The timeout flag is set on a timeout only while interrupt enable is 1. `irq` is high exactly when both the flag and the interrupt enable are set, and it rises at the clock edge of the timeout.
- R5: `irq_ack` clears the flag. A control write with bit 7 = 1 clears the flag, and a write with bit 7 = 0 leaves it unchanged. In interrupt-only mode an acknowledge keeps interrupt enable at 1.
- R6: With interrupt enable 1 and reset enable 0, timeouts set the flag and never assert `sys_rst_out`.
- R7: With both enables 1, the first timeout sets the flag without a reset. An acknowledge clears both the flag and interrupt enable, so the next timeout asserts `sys_rst_out`.
- R8: With reset enable 1 and interrupt enable 0, a timeout asserts `sys_rst_out` from that edge until the next tick edge. It also sets bit 0 of the reset-flag register at address 0x34.
- R9: With both enables 0, a timeout changes no flag and asserts no output.
- R10: A control write is accepted only on the 1st to 4th clock edge after the byte 0xD8 is written to address 0x3C. Any other control write, including one after a different key byte, is ignored. A repeated key write reloads the window.
- R11: A write to the reset-flag register with bit 0 = 0 clears the flag, and a write with bit 0 = 1 leaves it unchanged. No key is needed.
- R12: `bus_rdata` is registered: it carries the addressed register one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow time-base enable, one cycle per tick |
| wd_restart | input | 1 | Clears the timeout counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Interrupt acknowledge from the interrupt controller |
| irq | output | 1 | Interrupt request |
| sys_rst_out | output | 1 | System reset request |

## Verification
Register writes, acknowledges and timeouts take effect at the clock edge where they are sampled. So the flag, the enables, `irq` and `sys_rst_out` are checked at the falling edge right after that edge. Read data arrives one edge later, and the read task samples it at the falling edge after the read strobe. The bench holds `tick` low except inside its tick task, so it knows the exact counter value. Timeouts are then checked one tick before and on the tick they are due. The stretched reset pulse is checked across idle cycles between sparse ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       flag;
    logic       ien;
    logic [3:0] psel;
    logic       ren;
  } wd_ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(wd_ctrl_t c);
    return {c.flag, c.ien, c.psel[3], 1'b0, c.ren, c.psel[2:0]};
  endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE_SHIFT = 11,
  parameter int NUM_CODES  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic [3:0] psel,
  output logic       timeout
);
  localparam int CNT_W = BASE_SHIFT + NUM_CODES - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit_m1;
  logic [3:0]       sel_eff;

  always_comb begin
    sel_eff  = (int'(psel) < NUM_CODES) ? psel : 4'd0;
    limit_m1 = (CNT_W'(1) << (BASE_SHIFT + int'(sel_eff))) - CNT_W'(1);
    timeout  = tick && !restart && (cnt >= limit_m1);
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= timeout ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic key_wr,
  output logic unlocked
);
  localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);

  logic [WIN_W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst)               win <= '0;
    else if (key_wr)       win <= WIN_W'(UNLOCK_CYCLES);
    else if (win != '0)    win <= win - WIN_W'(1);
  end

  assign unlocked = (win != '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [6:0] wfield,
  input  logic       flag_clr_we,
  input  logic       irq_ack,
  input  logic       timeout,
  input  logic       tick,
  output wd_ctrl_t   ctrl,
  output logic       wdrf,
  output logic       irq,
  output logic       sys_rst
);
  wd_ctrl_t nxt;
  logic     hit_irq;
  logic     hit_rst;

  assign hit_irq = timeout && ctrl.ien;
  assign hit_rst = timeout && ctrl.ren && !ctrl.ien;

  always_comb begin
    nxt = ctrl;
    if (ctrl_we) begin
      if (wfield[6]) nxt.flag = 1'b0;
      nxt.ien  = wfield[5];
      nxt.psel = {wfield[4], wfield[2:0]};
      nxt.ren  = wfield[3];
    end
    if (irq_ack) begin
      nxt.flag = 1'b0;
      if (nxt.ren) nxt.ien = 1'b0;
    end
    if (hit_irq) nxt.flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      wdrf    <= 1'b0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      ctrl <= nxt;
      irq  <= nxt.flag && nxt.ien;
      if (hit_rst)   sys_rst <= 1'b1;
      else if (tick) sys_rst <= 1'b0;
      if (hit_rst)          wdrf <= 1'b1;
      else if (flag_clr_we) wdrf <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_irq_rst.sv
module wdog_irq_rst
  import wdog_pkg::*;
#(
  parameter int                BASE_SHIFT    = 11,
  parameter int                NUM_CODES     = 10,
  parameter int                UNLOCK_CYCLES = 4,
  parameter int                ADDR_W        = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = 'h31,
  parameter logic [ADDR_W-1:0] FLAG_ADDR     = 'h34,
  parameter logic [ADDR_W-1:0] KEY_ADDR      = 'h3C,
  parameter logic [7:0]        KEY_VALUE     = 8'hD8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wd_restart,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              sys_rst_out
);
  wd_ctrl_t ctrl_q;
  logic     timeout;
  logic     unlocked;
  logic     hit_ctrl;
  logic     key_wr;
  logic     flag_clr_we;
  logic     wdrf;

  assign hit_ctrl    = bus_wr && (bus_addr == CTRL_ADDR);
  assign key_wr      = bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata == KEY_VALUE);
  assign flag_clr_we = bus_wr && (bus_addr == FLAG_ADDR) && !bus_wdata[0];

  wdog_prescale #(
    .BASE_SHIFT (BASE_SHIFT),
    .NUM_CODES  (NUM_CODES)
  ) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (wd_restart),
    .psel    (ctrl_q.psel),
    .timeout (timeout)
  );

  wdog_unlock #(
    .UNLOCK_CYCLES (UNLOCK_CYCLES)
  ) u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .unlocked (unlocked)
  );

  wdog_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ctrl_we     (hit_ctrl && unlocked),
    .wfield      ({bus_wdata[7:5], bus_wdata[3:0]}),
    .flag_clr_we (flag_clr_we),
    .irq_ack     (irq_ack),
    .timeout     (timeout),
    .tick        (tick),
    .ctrl        (ctrl_q),
    .wdrf        (wdrf),
    .irq         (irq),
    .sys_rst     (sys_rst_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == CTRL_ADDR)      bus_rdata <= ctrl_to_byte(ctrl_q);
      else if (bus_addr == FLAG_ADDR) bus_rdata <= {7'b0, wdrf};
      else                            bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdog_irq_rst_chk.sv
module wdog_irq_rst_chk
  import wdog_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     tick,
  input logic     irq_ack,
  input logic     irq,
  input logic     sys_rst,
  input logic     timeout,
  input logic     unlocked,
  input logic     hit_ctrl,
  input logic     wdrf,
  input wd_ctrl_t ctrl
);
  AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl.ien);  // R4
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !timeout) |=> !irq);  // R5
  AST_COMBINED_ACK_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && ctrl.ren && !hit_ctrl) |=> !ctrl.ien);  // R7
  AST_RST_ONLY_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> $past(ctrl.ren && !ctrl.ien));  // R8
  AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> wdrf);  // R8
  AST_RST_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (sys_rst && tick && !timeout) |=> !sys_rst);  // R8
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hit_ctrl && !unlocked && !irq_ack && !timeout) |=> $stable(ctrl));  // R10
endmodule

bind wdog_irq_rst wdog_irq_rst_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .sys_rst  (sys_rst_out),
  .timeout  (timeout),
  .unlocked (unlocked),
  .hit_ctrl (hit_ctrl),
  .wdrf     (wdrf),
  .ctrl     (ctrl_q)
);

// File: tb/test_wdog_irq_rst.sv
`timescale 1ns/100ps
module test_wdog_irq_rst;
  localparam int         BASE     = 4;
  localparam logic [5:0] A_CTRL   = 6'h31;
  localparam logic [5:0] A_FLAG   = 6'h34;
  localparam logic [5:0] A_KEY    = 6'h3C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wd_restart = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       sys_rst_out;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;

  always #2.5 clk = ~clk;

  wdog_irq_rst #(.BASE_SHIFT(BASE)) i_wdog_irq_rst (
    .clk(clk), .rst(rst), .tick(tick), .wd_restart(wd_restart),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq(irq), .sys_rst_out(sys_rst_out)
  );

  always @(negedge clk) if (!rst && sys_rst_out) rst_seen++;

  function automatic int period(int p);
    return (p > 9) ? (1 << BASE) : ((1 << BASE) << p);
  endfunction

  function automatic logic [7:0] after_write(logic [7:0] old, logic [7:0] d);
    return {(d[7] ? 1'b0 : old[7]), d[6], d[5], 1'b0, d[3], d[2:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic unlock_wr(input logic [7:0] d);
    wr(A_KEY, 8'hD8);
    wr(A_CTRL, d);
  endtask

  task automatic restart();
    wd_restart = 1'b1;
    @(negedge clk);
    wd_restart = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] model;
    int base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 read timing
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst_out, 0);
    rd(A_CTRL, rv); check("R1 R12 ctrl", rv, 8'h00);
    rd(A_FLAG, rv); check("R1 flag", rv, 8'h00);

    // interrupt-only mode
    unlock_wr(8'h40);
    restart();
    ticks(period(0) - 1, 0);
    check("R3 no early timeout", irq, 0);
    ticks(1, 0);
    check("R4 irq on timeout", irq, 1);
    rd(A_CTRL, rv); check("R2 R4 ctrl flag set", rv, 8'hC0);
    ticks(40, 0);
    check("R6 no reset in irq mode", rst_seen, 0);
    ack();
    check("R5 ack drops irq", irq, 0);
    rd(A_CTRL, rv); check("R5 ien kept", rv, 8'h40);
    restart();
    ticks(period(0), 0);
    check("R4 irq again", irq, 1);
    unlock_wr(8'h40);
    rd(A_CTRL, rv); check("R5 write zero keeps flag", rv, 8'hC0);
    unlock_wr(8'hC0);
    rd(A_CTRL, rv); check("R5 write one clears flag", rv, 8'h40);
    check("R5 irq low after w1c", irq, 0);

    // restart mid-count
    restart();
    ticks(10, 0);
    restart();
    ticks(10, 0);
    check("R3 restart clears count", irq, 0);

    // combined mode
    unlock_wr(8'h48);
    restart();
    ticks(period(0), 0);
    check("R7 first timeout irq", irq, 1);
    check("R7 first timeout no reset", sys_rst_out, 0);
    ack();
    rd(A_CTRL, rv); check("R7 ack disarms ien", rv, 8'h08);
    restart();
    ticks(period(0) - 1, 0);
    check("R7 no early reset", sys_rst_out, 0);
    ticks(1, 0);
    check("R7 second timeout resets", sys_rst_out, 1);
    rd(A_FLAG, rv); check("R8 reset flag set", rv, 8'h01);
    ticks(1, 0);
    check("R8 reset ends at next tick", sys_rst_out, 0);
    check("R7 irq stays low", irq, 0);

    // reset flag register
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, rv); check("R11 write one keeps flag", rv, 8'h01);
    wr(A_FLAG, 8'hFE);
    rd(A_FLAG, rv); check("R11 write zero clears", rv, 8'h00);

    // reset-only mode, sparse ticks
    unlock_wr(8'h08);
    restart();
    ticks(period(0) - 1, 2);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R8 reset asserted", sys_rst_out, 1);
    @(negedge clk);
    check("R8 reset held between ticks", sys_rst_out, 1);
    @(negedge clk);
    check("R8 reset held until tick", sys_rst_out, 1);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R8 reset released", sys_rst_out, 0);

    // both enables off
    wr(A_FLAG, 8'h00);
    unlock_wr(8'h00);
    restart();
    base = rst_seen;
    ticks(period(0) * 3, 0);
    check("R9 no irq", irq, 0);
    check("R9 no reset", rst_seen, base);
    rd(A_FLAG, rv); check("R9 flag untouched", rv, 8'h00);
    rd(A_CTRL, rv); check("R9 ctrl untouched", rv, 8'h00);

    // prescale codes: 1, 9, reserved 12, reserved 15
    begin
      logic [7:0] code_byte [4] = '{8'h41, 8'h61, 8'h64, 8'h67};
      int         code_val  [4] = '{1, 9, 12, 15};
      for (int k = 0; k < 4; k++) begin
        unlock_wr(code_byte[k]);
        restart();
        ticks(period(code_val[k]) - 1, 0);
        check($sformatf("R3 code %0d early", code_val[k]), irq, 0);
        ticks(1, 0);
        check($sformatf("R3 code %0d due", code_val[k]), irq, 1);
        ack();
      end
    end

    // key window directed
    unlock_wr(8'h00);
    repeat (5) @(negedge clk);
    wr(A_KEY, 8'hD8); repeat (3) @(negedge clk); wr(A_CTRL, 8'h05);
    rd(A_CTRL, rv); check("R10 fourth edge accepted", rv, 8'h05);
    repeat (5) @(negedge clk);
    wr(A_KEY, 8'hD8); repeat (4) @(negedge clk); wr(A_CTRL, 8'h03);
    rd(A_CTRL, rv); check("R10 fifth edge ignored", rv, 8'h05);
    repeat (5) @(negedge clk);
    wr(A_KEY, 8'hD8); repeat (2) @(negedge clk);
    wr(A_KEY, 8'hD8); repeat (3) @(negedge clk); wr(A_CTRL, 8'h02);
    rd(A_CTRL, rv); check("R10 reload accepted", rv, 8'h02);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, rv); check("R10 no key ignored", rv, 8'h02);
    wr(A_KEY, 8'hD7); wr(A_CTRL, 8'h01);
    rd(A_CTRL, rv); check("R10 wrong key ignored", rv, 8'h02);

    // random key/write sequences, counter frozen (tick low)
    model = 8'h02;
    for (int it = 0; it < 60; it++) begin
      int d;
      int kind;
      logic [7:0] val;
      repeat (5) @(negedge clk);
      d    = $urandom % 7;
      kind = $urandom % 4;
      val  = 8'($urandom);
      if (kind == 1) wr(A_KEY, 8'($urandom % 216));
      else if (kind >= 2) wr(A_KEY, 8'hD8);
      repeat (d) @(negedge clk);
      wr(A_CTRL, val);
      if (kind >= 2 && d <= 3) model = after_write(model, val);
      rd(A_CTRL, rv);
      check("R10 R2 random write", rv, model);
    end
    unlock_wr(8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule